// File: doc/BRIEF.md
# Display Panel Bring-Up and Shutdown Sequencer

This block steps a display panel through its power states by issuing a fixed series of register writes to an external 9-bit serial writer. It holds four scripts: a long bring-up script, a one-command display-on script, a one-command display-off script and a short shutdown script. The bring-up script opens with three wake-up commands, each followed by a timed pause. It then leaves deep standby, enables the boosters and supply rails, programs the output control, leaves sleep and loads a 34-entry configuration table. Shutdown blanks the outputs, puts the panel to sleep and turns the supplies off.

Each write goes to the writer as a request carrying a kind, a register address and up to two data bytes. The request is held until the writer returns done, together with an error flag. A failure during bring-up ends that script at once. A failure during shutdown is recorded, and the script still runs to its end. A sticky error output reports any failure until the next bring-up starts. The host sees a single busy output and may issue a new request only while busy is low.

Top module: `panel_power_seq`

## Requirements
- R1: After reset, busy, wrReq and errFlag are all low.
- R2: A request pulse is accepted only on a cycle where busy is low; requests that arrive while busy is high produce no write. When several request inputs are high together, the priority order is prepare, then unprepare, then enable, then disable, and only the winning script runs.
- R3: A prepare begins with three command-only writes of register 0x00. After the done of each of these, at least GAP_CYCLES clock cycles pass before the next write request rises.
- R4: After the wake-up commands, prepare issues 0x17 to 0xB0, 0x80 to 0xBC, 0x00 to 0x3B and 0x16 to 0xB0 as one-byte writes. These are followed by a two-byte write of 0xFFF9 to 0xB8, a command-only 0x11 and then the 34 configuration writes, for 43 writes in total. wrKind is encoded as 0 for command-only, 1 for one data byte (in wrData[7:0], with the upper byte zero) and 2 for two data bytes (wrData[15:8] sent first).
- R5: Enable issues the command-only write 0x29 and nothing else. Disable issues the command-only write 0x28 and nothing else.
- R6: Unprepare issues three writes in this order: a two-byte write of 0x8002 to 0xB8, a command-only 0x10 and a one-byte write of 0x00 to 0xB0.
- R7: Once wrReq is raised, it stays high with wrKind, wrReg and wrData unchanged until the cycle in which wrDone is sampled. wrReq is low on the following cycle.
- R8: If any prepare write returns done with wrErr high, no further write of that prepare is issued, and busy is low on the cycle after that done.
- R9: An unprepare issues all three of its writes even when an earlier one returns an error.
- R10: errFlag goes high after a done that carries wrErr. It then stays high through enable, disable and unprepare, and it is low on the cycle after a prepare request is accepted.
- R11: Busy is high on the cycle after a request is accepted. It stays high while the script runs and is low again within two cycles after the last write's done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqPrepare | input | 1 | Start the bring-up script |
| reqEnable | input | 1 | Start the display-on script |
| reqDisable | input | 1 | Start the display-off script |
| reqUnprepare | input | 1 | Start the shutdown script |
| busy | output | 1 | A script is running |
| errFlag | output | 1 | Sticky writer failure flag |
| wrReq | output | 1 | Write request to the serial writer, held until done |
| wrKind | output | 2 | 0 command-only, 1 one byte, 2 two bytes |
| wrReg | output | 8 | Command or register byte |
| wrData | output | 16 | Data bytes, high byte first for two-byte writes |
| wrDone | input | 1 | Writer finished the current write |
| wrErr | input | 1 | Writer failure, valid with wrDone |

## Verification
The assertions check the write handshake, the sticky error flag, the rise of busy, the quiet request line while idle and the early end of a failed bring-up on every cycle. Only the bench scenarios can show that the scripts carry the right commands, data and kinds in the right order. The same holds for the length of the wake-up pauses, the request priority, and the rule that shutdown runs to completion after an error. A scoreboard compares each write the writer model receives against the expected script.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  localparam int PC_W = 6;

  typedef enum logic [2:0] {
    K_CMD = 3'd0,
    K_ONE = 3'd1,
    K_TWO = 3'd2,
    K_GAP = 3'd3,
    K_END = 3'd4
  } stepKind_t;

  typedef struct packed {
    stepKind_t   kind;
    logic [7:0]  addr;
    logic [15:0] val;
  } step_t;

  typedef enum logic [1:0] {
    SEL_UP   = 2'd0,
    SEL_ON   = 2'd1,
    SEL_OFF  = 2'd2,
    SEL_DOWN = 2'd3
  } entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic incPc;
    logic loadGap;
    logic decGap;
    logic issue;
    logic retire;
    logic setErr;
    logic clrErr;
  } strobe_t;

  localparam logic [PC_W-1:0] START_UP   = PC_W'(0);
  localparam logic [PC_W-1:0] START_ON   = PC_W'(47);
  localparam logic [PC_W-1:0] START_OFF  = PC_W'(49);
  localparam logic [PC_W-1:0] START_DOWN = PC_W'(51);

endpackage

// File: rtl/panel_seq_rom.sv
module panel_seq_rom
  import panel_seq_pkg::*;
(
  input  logic [PC_W-1:0] pc,
  output step_t           step
);

  function automatic step_t mk(input stepKind_t k, input logic [7:0] a, input logic [15:0] v);
    step_t s;
    s.kind = k;
    s.addr = a;
    s.val  = v;
    return s;
  endfunction

  always_comb begin
    case (pc)
      // wake-up preamble
      6'd0:  step = mk(K_CMD, 8'h00, 16'h0000);
      6'd1:  step = mk(K_GAP, 8'h00, 16'h0000);
      6'd2:  step = mk(K_CMD, 8'h00, 16'h0000);
      6'd3:  step = mk(K_GAP, 8'h00, 16'h0000);
      6'd4:  step = mk(K_CMD, 8'h00, 16'h0000);
      6'd5:  step = mk(K_GAP, 8'h00, 16'h0000);
      // standby exit, rails, output control, sleep exit
      6'd6:  step = mk(K_ONE, 8'hB0, 16'h0017);
      6'd7:  step = mk(K_ONE, 8'hBC, 16'h0080);
      6'd8:  step = mk(K_ONE, 8'h3B, 16'h0000);
      6'd9:  step = mk(K_ONE, 8'hB0, 16'h0016);
      6'd10: step = mk(K_TWO, 8'hB8, 16'hFFF9);
      6'd11: step = mk(K_CMD, 8'h11, 16'h0000);
      // configuration table
      6'd12: step = mk(K_ONE, 8'hBA, 16'h0001);
      6'd13: step = mk(K_ONE, 8'hBB, 16'h0000);
      6'd14: step = mk(K_ONE, 8'h3A, 16'h0060);
      6'd15: step = mk(K_ONE, 8'hBF, 16'h0010);
      6'd16: step = mk(K_ONE, 8'hB1, 16'h0056);
      6'd17: step = mk(K_ONE, 8'hB2, 16'h0033);
      6'd18: step = mk(K_ONE, 8'hB3, 16'h0011);
      6'd19: step = mk(K_ONE, 8'hB3, 16'h0011);
      6'd20: step = mk(K_ONE, 8'hB4, 16'h0002);
      6'd21: step = mk(K_ONE, 8'hB5, 16'h002B);
      6'd22: step = mk(K_ONE, 8'hB6, 16'h0040);
      6'd23: step = mk(K_ONE, 8'hB7, 16'h0003);
      6'd24: step = mk(K_ONE, 8'hB9, 16'h0004);
      6'd25: step = mk(K_ONE, 8'hBD, 16'h0004);
      6'd26: step = mk(K_ONE, 8'hBE, 16'h0000);
      6'd27: step = mk(K_ONE, 8'hC0, 16'h0011);
      6'd28: step = mk(K_ONE, 8'hC1, 16'h0011);
      6'd29: step = mk(K_ONE, 8'hC2, 16'h0011);
      6'd30: step = mk(K_TWO, 8'hC3, 16'h2040);
      6'd31: step = mk(K_TWO, 8'hC4, 16'h60C0);
      6'd32: step = mk(K_TWO, 8'hC5, 16'h1020);
      6'd33: step = mk(K_TWO, 8'hC6, 16'h60C0);
      6'd34: step = mk(K_TWO, 8'hC7, 16'h5533);
      6'd35: step = mk(K_ONE, 8'hC8, 16'h0000);
      6'd36: step = mk(K_ONE, 8'hC9, 16'h0000);
      6'd37: step = mk(K_ONE, 8'hCA, 16'h0000);
      6'd38: step = mk(K_TWO, 8'hEC, 16'h01F0);
      6'd39: step = mk(K_ONE, 8'hCF, 16'h0002);
      6'd40: step = mk(K_TWO, 8'hD0, 16'h0804);
      6'd41: step = mk(K_ONE, 8'hD1, 16'h0001);
      6'd42: step = mk(K_TWO, 8'hD2, 16'h0000);
      6'd43: step = mk(K_TWO, 8'hD3, 16'h0D0E);
      6'd44: step = mk(K_TWO, 8'hD4, 16'h11A4);
      6'd45: step = mk(K_ONE, 8'hD5, 16'h000E);
      6'd46: step = mk(K_END, 8'h00, 16'h0000);
      // display on
      6'd47: step = mk(K_CMD, 8'h29, 16'h0000);
      6'd48: step = mk(K_END, 8'h00, 16'h0000);
      // display off
      6'd49: step = mk(K_CMD, 8'h28, 16'h0000);
      6'd50: step = mk(K_END, 8'h00, 16'h0000);
      // shutdown
      6'd51: step = mk(K_TWO, 8'hB8, 16'h8002);
      6'd52: step = mk(K_CMD, 8'h10, 16'h0000);
      6'd53: step = mk(K_ONE, 8'hB0, 16'h0000);
      default: step = mk(K_END, 8'h00, 16'h0000);
    endcase
  end

endmodule

// File: rtl/panel_seq_dp.sv
module panel_seq_dp
  import panel_seq_pkg::*;
#(
  parameter int GAP_CYCLES = 100000
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strobe,
  input  entry_t      startSel,
  output stepKind_t   curKind,
  output logic        gapDone,
  output logic        wrReq,
  output logic [1:0]  wrKind,
  output logic [7:0]  wrReg,
  output logic [15:0] wrData,
  output logic        errFlag
);

  localparam int CNT_W = $clog2(GAP_CYCLES + 1);

  logic [PC_W-1:0]  pc;
  logic [CNT_W-1:0] gapCnt;
  step_t            step;
  logic [PC_W-1:0]  startPc;

  panel_seq_rom u_rom (
    .pc   (pc),
    .step (step)
  );

  assign curKind = step.kind;
  assign gapDone = (gapCnt == '0);

  always_comb begin
    case (startSel)
      SEL_UP:   startPc = START_UP;
      SEL_ON:   startPc = START_ON;
      SEL_OFF:  startPc = START_OFF;
      default:  startPc = START_DOWN;
    endcase
  end

  // script position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0;
    end else if (strobe.loadStart) begin
      pc <= startPc;
    end else if (strobe.incPc) begin
      pc <= pc + 1'b1;
    end
  end

  // wake-up pause counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (strobe.loadGap) begin
      gapCnt <= CNT_W'(GAP_CYCLES - 1);
    end else if (strobe.decGap && !gapDone) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  // writer request and its fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrReq  <= 1'b0;
      wrKind <= 2'd0;
      wrReg  <= 8'h00;
      wrData <= 16'h0000;
    end else if (strobe.issue) begin
      wrReq  <= 1'b1;
      wrKind <= step.kind[1:0];
      wrReg  <= step.addr;
      wrData <= step.val;
    end else if (strobe.retire) begin
      wrReq  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (strobe.clrErr) begin
      errFlag <= 1'b0;
    end else if (strobe.setErr) begin
      errFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
  import panel_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqPrepare,
  input  logic      reqEnable,
  input  logic      reqDisable,
  input  logic      reqUnprepare,
  input  logic      wrDone,
  input  logic      wrErr,
  input  stepKind_t curKind,
  input  logic      gapDone,
  output strobe_t   strobe,
  output entry_t    startSel,
  output logic      busy
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_GAP} state_t;

  state_t state, stateNext;
  logic   abortOnErr, abortNext;
  logic   anyReq;

  assign anyReq = reqPrepare | reqEnable | reqDisable | reqUnprepare;
  assign busy   = (state != S_IDLE);

  // fixed priority among simultaneous requests
  always_comb begin
    if (reqPrepare)        startSel = SEL_UP;
    else if (reqUnprepare) startSel = SEL_DOWN;
    else if (reqEnable)    startSel = SEL_ON;
    else                   startSel = SEL_OFF;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    abortNext = abortOnErr;
    case (state)
      S_IDLE: begin
        if (anyReq) begin
          strobe.loadStart = 1'b1;
          strobe.clrErr    = reqPrepare;
          abortNext        = reqPrepare;
          stateNext        = S_ISSUE;
        end
      end
      S_ISSUE: begin
        case (curKind)
          K_END: stateNext = S_IDLE;
          K_GAP: begin
            strobe.loadGap = 1'b1;
            stateNext      = S_GAP;
          end
          default: begin
            strobe.issue = 1'b1;
            stateNext    = S_WAIT;
          end
        endcase
      end
      S_WAIT: begin
        if (wrDone) begin
          strobe.retire = 1'b1;
          strobe.setErr = wrErr;
          if (wrErr && abortOnErr) begin
            stateNext = S_IDLE;
          end else begin
            strobe.incPc = 1'b1;
            stateNext    = S_ISSUE;
          end
        end
      end
      S_GAP: begin
        if (gapDone) begin
          strobe.incPc = 1'b1;
          stateNext    = S_ISSUE;
        end else begin
          strobe.decGap = 1'b1;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      abortOnErr <= 1'b0;
    end else begin
      state      <= stateNext;
      abortOnErr <= abortNext;
    end
  end

endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
  import panel_seq_pkg::*;
#(
  parameter int GAP_CYCLES = 100000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqPrepare,
  input  logic        reqEnable,
  input  logic        reqDisable,
  input  logic        reqUnprepare,
  output logic        busy,
  output logic        errFlag,
  output logic        wrReq,
  output logic [1:0]  wrKind,
  output logic [7:0]  wrReg,
  output logic [15:0] wrData,
  input  logic        wrDone,
  input  logic        wrErr
);

  strobe_t   strobe;
  entry_t    startSel;
  stepKind_t curKind;
  logic      gapDone;

  panel_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqPrepare   (reqPrepare),
    .reqEnable    (reqEnable),
    .reqDisable   (reqDisable),
    .reqUnprepare (reqUnprepare),
    .wrDone       (wrDone),
    .wrErr        (wrErr),
    .curKind      (curKind),
    .gapDone      (gapDone),
    .strobe       (strobe),
    .startSel     (startSel),
    .busy         (busy)
  );

  panel_seq_dp #(
    .GAP_CYCLES (GAP_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .startSel (startSel),
    .curKind  (curKind),
    .gapDone  (gapDone),
    .wrReq    (wrReq),
    .wrKind   (wrKind),
    .wrReg    (wrReg),
    .wrData   (wrData),
    .errFlag  (errFlag)
  );

endmodule

// File: rtl/panel_seq_chk.sv
module panel_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqPrepare,
  input logic        reqEnable,
  input logic        reqDisable,
  input logic        reqUnprepare,
  input logic        busy,
  input logic        errFlag,
  input logic        wrReq,
  input logic [1:0]  wrKind,
  input logic [7:0]  wrReg,
  input logic [15:0] wrData,
  input logic        wrDone,
  input logic        wrErr
);

  logic anyReq;
  logic prepMode;

  assign anyReq = reqPrepare | reqEnable | reqDisable | reqUnprepare;

  // tracks which script is running, from the ports alone
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prepMode <= 1'b0;
    else if (!busy && anyReq) prepMode <= reqPrepare;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> !busy && !wrReq && !errFlag); // R1

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !wrReq); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !wrDone |=> wrReq && $stable(wrKind) && $stable(wrReg) && $stable(wrData)); // R7

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && wrDone |=> !wrReq); // R7

  AST_ABORT_PREP: assert property (@(posedge clk) disable iff (!rstN)
    prepMode && busy && wrReq && wrDone && wrErr |=> !busy); // R8

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && wrDone && wrErr |=> errFlag); // R10

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !busy && reqPrepare |=> !errFlag); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !(!busy && reqPrepare) |=> errFlag); // R10

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !busy && anyReq |=> busy); // R11

endmodule

bind panel_power_seq panel_seq_chk u_chk (.*);

// File: tb/test_panel_power_seq.sv
module test_panel_power_seq;

  localparam int GAP = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqPrepare = 1'b0;
  logic        reqEnable = 1'b0;
  logic        reqDisable = 1'b0;
  logic        reqUnprepare = 1'b0;
  logic        wrDone = 1'b0;
  logic        wrErr = 1'b0;
  logic        busy, errFlag, wrReq;
  logic [1:0]  wrKind;
  logic [7:0]  wrReg;
  logic [15:0] wrData;

  always #2.5 clk = ~clk;

  panel_power_seq #(.GAP_CYCLES(GAP)) i_panel_power_seq (
    .clk(clk), .rstN(rstN),
    .reqPrepare(reqPrepare), .reqEnable(reqEnable),
    .reqDisable(reqDisable), .reqUnprepare(reqUnprepare),
    .busy(busy), .errFlag(errFlag),
    .wrReq(wrReq), .wrKind(wrKind), .wrReg(wrReg), .wrData(wrData),
    .wrDone(wrDone), .wrErr(wrErr)
  );

  typedef struct packed {
    logic [1:0]  k;
    logic [7:0]  r;
    logic [15:0] d;
    logic        g;
  } exp_t;

  exp_t    expQ[$];
  int      nCmp = 0;
  int      nBad = 0;
  int      latency = 1;
  int      failAt = -1;
  int      wrCount = 0;
  int      pushLimit = 1000;
  int      pushed = 0;
  longint  cyc = 0;
  longint  lastDone = 0;
  string   curTag = "R4";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // driver side: expected writes into the scoreboard
  task automatic pushW(input logic [1:0] k, input logic [7:0] r, input logic [15:0] d,
                       input logic g);
    if (pushed < pushLimit) expQ.push_back({k, r, d, g});
    pushed++;
  endtask

  task automatic pushPrepare(input int limit);
    pushed = 0;
    pushLimit = limit;
    pushW(0, 8'h00, 16'h0000, 0);
    pushW(0, 8'h00, 16'h0000, 1);
    pushW(0, 8'h00, 16'h0000, 1);
    pushW(1, 8'hB0, 16'h0017, 1);
    pushW(1, 8'hBC, 16'h0080, 0);
    pushW(1, 8'h3B, 16'h0000, 0);
    pushW(1, 8'hB0, 16'h0016, 0);
    pushW(2, 8'hB8, 16'hFFF9, 0);
    pushW(0, 8'h11, 16'h0000, 0);
    pushW(1, 8'hBA, 16'h0001, 0);
    pushW(1, 8'hBB, 16'h0000, 0);
    pushW(1, 8'h3A, 16'h0060, 0);
    pushW(1, 8'hBF, 16'h0010, 0);
    pushW(1, 8'hB1, 16'h0056, 0);
    pushW(1, 8'hB2, 16'h0033, 0);
    pushW(1, 8'hB3, 16'h0011, 0);
    pushW(1, 8'hB3, 16'h0011, 0);
    pushW(1, 8'hB4, 16'h0002, 0);
    pushW(1, 8'hB5, 16'h002B, 0);
    pushW(1, 8'hB6, 16'h0040, 0);
    pushW(1, 8'hB7, 16'h0003, 0);
    pushW(1, 8'hB9, 16'h0004, 0);
    pushW(1, 8'hBD, 16'h0004, 0);
    pushW(1, 8'hBE, 16'h0000, 0);
    pushW(1, 8'hC0, 16'h0011, 0);
    pushW(1, 8'hC1, 16'h0011, 0);
    pushW(1, 8'hC2, 16'h0011, 0);
    pushW(2, 8'hC3, 16'h2040, 0);
    pushW(2, 8'hC4, 16'h60C0, 0);
    pushW(2, 8'hC5, 16'h1020, 0);
    pushW(2, 8'hC6, 16'h60C0, 0);
    pushW(2, 8'hC7, 16'h5533, 0);
    pushW(1, 8'hC8, 16'h0000, 0);
    pushW(1, 8'hC9, 16'h0000, 0);
    pushW(1, 8'hCA, 16'h0000, 0);
    pushW(2, 8'hEC, 16'h01F0, 0);
    pushW(1, 8'hCF, 16'h0002, 0);
    pushW(2, 8'hD0, 16'h0804, 0);
    pushW(1, 8'hD1, 16'h0001, 0);
    pushW(2, 8'hD2, 16'h0000, 0);
    pushW(2, 8'hD3, 16'h0D0E, 0);
    pushW(2, 8'hD4, 16'h11A4, 0);
    pushW(1, 8'hD5, 16'h000E, 0);
    pushLimit = 1000;
  endtask

  task automatic pushUnprepare();
    pushed = 0;
    pushW(2, 8'hB8, 16'h8002, 0);
    pushW(0, 8'h10, 16'h0000, 0);
    pushW(1, 8'hB0, 16'h0000, 0);
  endtask

  // monitor: writer model that pops and compares
  initial begin
    forever begin
      @(negedge clk);
      if (wrReq) begin
        exp_t e;
        logic [1:0]  k0;
        logic [7:0]  r0;
        logic [15:0] d0;
        wrCount++;
        k0 = wrKind; r0 = wrReg; d0 = wrData;
        if (expQ.size() == 0) begin
          check(0, "R2", "unexpected write reg", r0, 0);
        end else begin
          e = expQ.pop_front();
          check(k0 == e.k, curTag, "write kind", k0, e.k);
          check(r0 == e.r, curTag, "write reg", r0, e.r);
          check(d0 == e.d, curTag, "write data", d0, e.d);
          if (e.g) check(cyc - lastDone >= GAP, "R3", "cycles after wake-up done",
                         cyc - lastDone, GAP);
        end
        for (int i = 1; i < latency; i++) begin
          @(negedge clk);
          check(wrReq && wrKind == k0 && wrReg == r0 && wrData == d0, "R7",
                "request held stable", {wrReq, wrReg}, {1'b1, r0});
        end
        wrDone = 1'b1;
        wrErr  = (wrCount == failAt);
        @(negedge clk);
        wrDone = 1'b0;
        wrErr  = 1'b0;
        lastDone = cyc;
        check(!wrReq, "R7", "request dropped after done", wrReq, 0);
      end
    end
  end

  task automatic pulse(input bit p, input bit u, input bit en, input bit dis);
    @(negedge clk);
    reqPrepare = p; reqUnprepare = u; reqEnable = en; reqDisable = dis;
    @(negedge clk);
    reqPrepare = 0; reqUnprepare = 0; reqEnable = 0; reqDisable = 0;
    check(busy, "R11", "busy after accepted request", busy, 1);
  endtask

  task automatic waitIdle(input string tag);
    int n;
    n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(!busy, "R11", "busy falls at script end", busy, 0);
    repeat (GAP + 10) @(negedge clk);
    check(expQ.size() == 0, tag, "expected writes left over", expQ.size(), 0);
  endtask

  initial begin
    #400000;
    nBad++;
    nCmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !wrReq && !errFlag, "R1", "reset outputs",
          {busy, wrReq, errFlag}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !wrReq && !errFlag, "R1", "idle after reset",
          {busy, wrReq, errFlag}, 0);

    // R3 R4 full bring-up
    curTag = "R4";
    pushPrepare(1000);
    pulse(1, 0, 0, 0);
    waitIdle("R4");
    check(!errFlag, "R10", "no error after clean bring-up", errFlag, 0);

    // R5 display on, with slow writer to exercise R7 hold
    curTag = "R5";
    latency = 4;
    pushW(0, 8'h29, 16'h0000, 0);
    pulse(0, 0, 1, 0);
    // R2 requests while busy are ignored
    reqDisable = 1'b1; reqUnprepare = 1'b1;
    @(negedge clk);
    reqDisable = 1'b0; reqUnprepare = 1'b0;
    waitIdle("R2");
    latency = 1;

    curTag = "R5";
    pushW(0, 8'h28, 16'h0000, 0);
    pulse(0, 0, 0, 1);
    waitIdle("R5");

    // R2 priority: unprepare beats enable and disable
    curTag = "R6";
    pushUnprepare();
    pulse(0, 1, 1, 1);
    waitIdle("R6");

    // R8 bring-up aborts on the seventh write
    curTag = "R8";
    failAt = wrCount + 7;
    pushPrepare(7);
    pulse(1, 0, 0, 0);
    waitIdle("R8");
    check(errFlag, "R10", "error flag set by failed write", errFlag, 1);

    // R10 sticky through enable
    curTag = "R5";
    pushW(0, 8'h29, 16'h0000, 0);
    pulse(0, 0, 1, 0);
    waitIdle("R5");
    check(errFlag, "R10", "error flag sticky over enable", errFlag, 1);

    // R9 shutdown continues after error on its first write
    curTag = "R9";
    failAt = wrCount + 1;
    pushUnprepare();
    pulse(0, 1, 0, 0);
    waitIdle("R9");
    check(errFlag, "R10", "error flag after shutdown failure", errFlag, 1);

    // R10 cleared on next bring-up, which also wins over enable (R2)
    curTag = "R4";
    failAt = -1;
    latency = 2;
    pushPrepare(1000);
    pulse(1, 0, 1, 0);
    check(!errFlag, "R10", "error flag cleared at prepare start", errFlag, 1'b0);
    waitIdle("R4");
    check(!errFlag, "R10", "error flag low after clean bring-up", errFlag, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule